// File: doc/BRIEF.md
# Octal DDR Memory-Mapped Register Target

This block sits in an FPGA and answers a microcontroller's octal serial memory controller as if it were a small RAM, so that firmware reaches a bank of FPGA registers through plain loads and stores. Eight data lines carry one byte on each edge of the bus clock. A strobe line has two jobs. From the host during writes it marks filler bytes. From the target during reads it marks valid data.

Edge capture and launch are done by IO DDR registers outside the block. The block runs on the bus clock `clk`, and each cycle presents two bytes: the `_p` byte belongs to the rising edge and the `_n` byte to the falling edge. The whole transaction runs as a short phase machine, which returns to its idle state whenever chip select goes high:

- **ST_IDLE**: captures the command byte and the top address byte.
- **ST_CA_MID**: captures the lower address bytes and loads the byte pointer.
- **ST_CA_TAIL**: the last command/address cycle. Its bytes are ignored.
- **ST_DUMMY**: the latency cycles.
- **ST_WRITE**, **ST_READ** or **ST_SKIP**: the data phase, chosen by the command byte.

Transitions are IDLE to CA_MID to CA_TAIL to DUMMY, then DUMMY to WRITE, READ or SKIP. Any state goes to IDLE on chip select high.

Top module: `ospi_target_port`

## Requirements
- R1: While reset is asserted, and in every cycle where `cs_n` is high, `dq_oe` and `rwds_oe` are 0.
- R2: The command/address phase takes three cycles with `cs_n` low:
  - cycle 0 carries the command on `dq_in_p` and address bits [23:16] on `dq_in_n`;
  - cycle 1 carries bits [15:8] on `dq_in_p` and bits [7:0] on `dq_in_n`;
  - cycle 2 carries nothing used.

  The burst starts at the byte address with its low 3 bits forced to 0. Bits above the 256-byte space are ignored.
- R3: The command byte selects the data phase:
  - 0xA0 is a write;
  - 0x20 is a read;
  - 0x00 is also a read;
  - any other value neither drives the bus nor changes storage.
- R4: Exactly DUMMY_CYC cycles (default 1) follow the address phase, and the bus is not driven during them. Data starts in the next cycle.
- R5: The data stream maps onto 32-bit words with their 16-bit halves exchanged. Within a word, stream bytes 0, 1, 2 and 3 land in bits [15:8], [7:0], [31:24] and [23:16]. A byte written at a stream address is returned by a read at that address.
- R6: During a write, a byte whose strobe sample (`rwds_in_p` or `rwds_in_n`) is 1 is not stored. This covers the filler bytes the host sends before a start that is not 8-byte aligned.
- R7: During a write, `dq_oe` and `rwds_oe` stay 0.
- R8: Each data cycle advances the byte pointer by 2. Addresses wrap modulo 256 bytes over the 64-word file.
- R9: During read data cycles, `dq_oe` and `rwds_oe` are 1, `rwds_out_p` is 1 and `rwds_out_n` is 0.
- R10: A burst has no length limit and ends only when `cs_n` rises. `cs_n` high in any phase returns the machine to ST_IDLE, and the next transaction is decoded from its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one period per byte pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dq_in_p | input | 8 | Data byte captured on the rising edge |
| dq_in_n | input | 8 | Data byte captured on the falling edge |
| rwds_in_p | input | 1 | Host strobe with the rising-edge byte (1 = mask) |
| rwds_in_n | input | 1 | Host strobe with the falling-edge byte (1 = mask) |
| dq_out_p | output | 8 | Read byte launched on the rising edge |
| dq_out_n | output | 8 | Read byte launched on the falling edge |
| dq_oe | output | 1 | Data line output enable |
| rwds_out_p | output | 1 | Strobe value on the rising edge |
| rwds_out_n | output | 1 | Strobe value on the falling edge |
| rwds_oe | output | 1 | Strobe output enable |

## Verification
A wrong phase state appears at the ports within one cycle. Either the output enables rise during a dummy cycle, a write or an ignored command, or they fail to rise in the first read data cycle. A wrong pointer or lane mapping does not show until read-back, where it appears as data returned from the wrong byte or wrong half. For that reason every write is followed by a read of the same range, including ranges that start misaligned or wrap.

A phase machine that misses a chip-select abort shows up on the very next transaction. Its command and address are decoded from the wrong cycle, so the wrong command or the wrong data comes back.

// File: rtl/ospi_tgt_pkg.sv
package ospi_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA_MID,
        ST_CA_TAIL,
        ST_DUMMY,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_STORE
    } op_kind_e;

    localparam logic [7:0] CODE_READ  = 8'h20;
    localparam logic [7:0] CODE_WRITE = 8'hA0;
    localparam logic [7:0] CODE_PROBE = 8'h00;

    function automatic op_kind_e decode_code(input logic [7:0] code);
        op_kind_e k;
        if (code == CODE_WRITE)
            k = OP_STORE;
        else if (code == CODE_READ || code == CODE_PROBE)
            k = OP_LOAD;
        else
            k = OP_NONE;
        return k;
    endfunction

endpackage

// File: rtl/ospi_tgt_fsm.sv
module ospi_tgt_fsm
    import ospi_tgt_pkg::*;
#(
    parameter int PTR_W     = 8,
    parameter int DUMMY_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [7:0]       dq_p,
    input  logic [7:0]       dq_n,
    output phase_e           phase,
    output logic [PTR_W-1:0] ptr
);

    localparam int                DCW       = (DUMMY_CYC > 1) ? $clog2(DUMMY_CYC) : 1;
    localparam logic [DCW-1:0]    DUMMY_END = DCW'(DUMMY_CYC - 1);
    localparam logic [PTR_W-1:0]  PTR_STEP  = PTR_W'(2);

    phase_e         state, state_nxt;
    op_kind_e       kind_q;
    logic [DCW-1:0] dcnt;
    logic [15:0]    ca_low;
    logic           ca_unused;

    assign ca_low    = {dq_p, dq_n};
    assign ca_unused = ^{ca_low[15:PTR_W], ca_low[2:0]};
    assign phase     = state;

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    state_nxt = ST_CA_MID;
            ST_CA_MID:  state_nxt = ST_CA_TAIL;
            ST_CA_TAIL: state_nxt = ST_DUMMY;
            ST_DUMMY: begin
                if (dcnt == DUMMY_END) begin
                    unique case (kind_q)
                        OP_STORE: state_nxt = ST_WRITE;
                        OP_LOAD:  state_nxt = ST_READ;
                        default:  state_nxt = ST_SKIP;
                    endcase
                end
            end
            ST_WRITE, ST_READ, ST_SKIP: state_nxt = state;
            default:    state_nxt = ST_IDLE;
        endcase
        if (cs_n)
            state_nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // command, latency counter and byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= OP_NONE;
            dcnt   <= '0;
            ptr    <= '0;
        end else if (!cs_n) begin
            unique case (state)
                ST_IDLE:   kind_q <= decode_code(dq_p);
                ST_CA_MID: begin
                    ptr  <= {ca_low[PTR_W-1:3], 3'b000};
                    dcnt <= '0;
                end
                ST_DUMMY:  dcnt <= dcnt + 1'b1;
                ST_WRITE, ST_READ: ptr <= ptr + PTR_STEP;
                default: ;
            endcase
        end
    end

    // R10
    // abort_to_idle_chk
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> state == ST_IDLE);

    // R8
    // ptr_step_chk
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (state == ST_WRITE || state == ST_READ)) |=> ptr == PTR_W'($past(ptr) + PTR_STEP));

    // R4
    // data_after_dummy_chk
    data_after_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_READ || state == ST_WRITE) && !($past(state) == ST_READ || $past(state) == ST_WRITE))
            |-> $past(state) == ST_DUMMY);

endmodule

// File: rtl/ospi_tgt_regfile.sv
module ospi_tgt_regfile #(
    parameter int WORDS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++)
                mem[w] <= '0;
        end else begin
            for (int b = 0; b < 4; b++)
                if (be[b])
                    mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign rdata = mem[idx];

    // R6
    // be_hold_chk
    be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be == 4'b0000) |=> mem[$past(idx)] == $past(rdata));

endmodule

// File: rtl/ospi_target_port.sv
module ospi_target_port
    import ospi_tgt_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int DUMMY_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [7:0] dq_in_p,
    input  logic [7:0] dq_in_n,
    input  logic       rwds_in_p,
    input  logic       rwds_in_n,
    output logic [7:0] dq_out_p,
    output logic [7:0] dq_out_n,
    output logic       dq_oe,
    output logic       rwds_out_p,
    output logic       rwds_out_n,
    output logic       rwds_oe
);

    localparam int IDX_W = $clog2(WORDS);
    localparam int PTR_W = IDX_W + 2;

    phase_e             phase;
    logic [PTR_W-1:0]   ptr;
    logic [IDX_W-1:0]   word_idx;
    logic               upper_half;
    logic [3:0]         be;
    logic [31:0]        wdata;
    logic [31:0]        rdata;
    logic               wr_cyc;
    logic               rd_cyc;

    ospi_tgt_fsm #(
        .PTR_W     (PTR_W),
        .DUMMY_CYC (DUMMY_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .dq_p  (dq_in_p),
        .dq_n  (dq_in_n),
        .phase (phase),
        .ptr   (ptr)
    );

    ospi_tgt_regfile #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (word_idx),
        .be    (be),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign word_idx   = ptr[PTR_W-1:2];
    assign upper_half = ptr[1];
    assign wr_cyc     = (phase == ST_WRITE) && !cs_n;
    assign rd_cyc     = (phase == ST_READ) && !cs_n;
    assign wdata      = {dq_in_p, dq_in_n, dq_in_p, dq_in_n};

    // lane enables: rising byte is the high byte of the addressed half
    always_comb begin
        be = 4'b0000;
        if (wr_cyc) begin
            if (upper_half) begin
                be[3] = !rwds_in_p;
                be[2] = !rwds_in_n;
            end else begin
                be[1] = !rwds_in_p;
                be[0] = !rwds_in_n;
            end
        end
    end

    // output process
    always_comb begin
        dq_oe      = rd_cyc;
        rwds_oe    = rd_cyc;
        rwds_out_p = rd_cyc;
        rwds_out_n = 1'b0;
        dq_out_p   = 8'h00;
        dq_out_n   = 8'h00;
        if (rd_cyc) begin
            dq_out_p = upper_half ? rdata[31:24] : rdata[15:8];
            dq_out_n = upper_half ? rdata[23:16] : rdata[7:0];
        end
    end

    // R1
    // release_chk
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dq_oe && !rwds_oe));

    // R7
    // write_no_drive_chk
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_WRITE) |-> (!dq_oe && !rwds_oe));

    // R9
    // strobe_phase_chk
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwds_oe |-> (dq_oe && rwds_out_p && !rwds_out_n));

    // R3
    // skip_quiet_chk
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_SKIP) |-> (!dq_oe && be == 4'b0000));

endmodule

// File: tb/tb_ospi_target_port.sv
`timescale 1ns/1ps
module tb_ospi_target_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic [7:0] dq_in_p, dq_in_n;
    logic       rwds_in_p, rwds_in_n;
    logic [7:0] dq_out_p, dq_out_n;
    logic       dq_oe, rwds_out_p, rwds_out_n, rwds_oe;

    int errs   = 0;
    int checks = 0;
    logic [31:0] model [64];

    always #2.5 clk = ~clk;

    ospi_target_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .dq_in_p(dq_in_p), .dq_in_n(dq_in_n),
        .rwds_in_p(rwds_in_p), .rwds_in_n(rwds_in_n),
        .dq_out_p(dq_out_p), .dq_out_n(dq_out_n), .dq_oe(dq_oe),
        .rwds_out_p(rwds_out_p), .rwds_out_n(rwds_out_n), .rwds_oe(rwds_oe)
    );

    // R5 lane of stream byte k: 0->1, 1->0, 2->3, 3->2
    function automatic int lane_of(int b);
        return ((b >> 1) & 1) * 2 + (((b & 1) != 0) ? 0 : 1);
    endfunction

    function automatic logic [7:0] mget(int b);
        int w;
        w = (b >> 2) & 63;
        return model[w][lane_of(b)*8 +: 8];
    endfunction

    task automatic mset(int b, logic [7:0] v);
        int w;
        w = (b >> 2) & 63;
        model[w][lane_of(b)*8 +: 8] = v;
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(logic cs, logic [7:0] p, logic [7:0] n, logic rp, logic rn);
        @(negedge clk);
        cs_n = cs; dq_in_p = p; dq_in_n = n; rwds_in_p = rp; rwds_in_n = rn;
        #1;
    endtask

    task automatic ca_phase(logic [7:0] op, logic [23:0] addr);
        drive(1'b0, op, addr[23:16], 1'b0, 1'b0);
        chk("R2 no drive in cmd cycle", {dq_oe, rwds_oe}, 0);
        drive(1'b0, addr[15:8], addr[7:0], 1'b0, 1'b0);
        drive(1'b0, 8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drive(1'b0, 8'($urandom), 8'($urandom), 1'b0, 1'b0);
        chk("R4 dummy cycle bus released", {dq_oe, rwds_oe}, 0);
    endtask

    task automatic end_burst();
        drive(1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
        chk("R10 cs high releases bus", {dq_oe, rwds_oe}, 0);
        drive(1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic wr_burst(logic [23:0] addr, int nbytes, bit rmask, int nfill);
        int base;
        base = int'(addr) & 32'hF8;
        ca_phase(8'hA0, addr);
        for (int i = 0; i < nbytes; i += 2) begin
            logic [7:0] p, n;
            logic mp, mn;
            p  = 8'($urandom);
            n  = 8'($urandom);
            mp = (i < nfill) || (rmask && ($urandom % 4 == 0));
            mn = (i + 1 < nfill) || (rmask && ($urandom % 4 == 0));
            drive(1'b0, p, n, mp, mn);
            chk("R7 no drive during write", {dq_oe, rwds_oe}, 0);
            if (!mp) mset(base + i, p);
            if (!mn) mset(base + i + 1, n);
        end
        end_burst();
    endtask

    task automatic rd_burst(logic [7:0] op, logic [23:0] addr, int nbytes);
        int base;
        base = int'(addr) & 32'hF8;
        ca_phase(op, addr);
        for (int i = 0; i < nbytes; i += 2) begin
            drive(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
            chk("R9 read strobe", {dq_oe, rwds_oe, rwds_out_p, rwds_out_n}, 4'b1110);
            chk("R5 R8 read data", {dq_out_p, dq_out_n}, {mget(base + i), mget(base + i + 1)});
        end
        end_burst();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R10 watchdog expired got=%0d exp=0", 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240815));
        for (int w = 0; w < 64; w++) model[w] = '0;
        rst_n = 1'b0; cs_n = 1'b1;
        dq_in_p = 0; dq_in_n = 0; rwds_in_p = 0; rwds_in_n = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 outputs released in reset", {dq_oe, rwds_oe}, 0);
        rst_n = 1'b1;
        drive(1'b1, 0, 0, 0, 0);
        chk("R1 idle released", {dq_oe, rwds_oe}, 0);

        // R5 known word round trip, with the R2 low bits ignored on read
        wr_burst(24'h000008, 8, 1'b0, 0);
        rd_burst(8'h20, 24'h00000D, 8);

        // R3 debug read code 0x00
        rd_burst(8'h00, 24'h000008, 8);

        // R6 misaligned start: three filler bytes masked
        wr_burst(24'h000010, 8, 1'b0, 0);
        wr_burst(24'h000013, 8, 1'b0, 3);
        rd_burst(8'h20, 24'h000010, 8);

        // R3 unknown code: no drive, no storage change
        ca_phase(8'h55, 24'h000010);
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 8'($urandom), 8'($urandom), 1'b0, 1'b0);
            chk("R3 ignored code does not drive", {dq_oe, rwds_oe}, 0);
        end
        end_burst();
        rd_burst(8'h20, 24'h000010, 8);

        // R8 wrap across the top of the space, R2 upper address bits ignored
        wr_burst(24'hABCDF8, 16, 1'b0, 0);
        rd_burst(8'h20, 24'h0000F8, 16);
        rd_burst(8'h20, 24'h000000, 8);

        // R10 abort in the address phase, then a clean read
        drive(1'b0, 8'hA0, 8'h00, 1'b0, 1'b0);
        drive(1'b0, 8'h00, 8'h10, 1'b0, 1'b0);
        drive(1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
        chk("R10 abort in address phase", {dq_oe, rwds_oe}, 0);
        rd_burst(8'h20, 24'h000010, 8);

        // R10 long burst with no byte limit
        wr_burst(24'h000040, 64, 1'b1, 0);
        rd_burst(8'h20, 24'h000040, 64);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [23:0] a;
            int nb;
            a  = 24'($urandom);
            nb = 2 * (1 + ($urandom % 12));
            wr_burst(a, nb, 1'b1, int'(a[2:0]));
            rd_burst(($urandom % 2 == 0) ? 8'h20 : 8'h00, a, nb);
        end

        summary();
        $finish;
    end

endmodule